// File: doc/BRIEF.md
# Inbound Serial Audio Frame Builder

This block runs on the codec side of a serial audio link, clocked by the link's bit clock. A rising edge on the shared frame-sync line starts a frame, and the block then drives 500 bit slots onto the inbound data line, one per rising clock edge. Slots are numbered 499 down to 0.

Each frame opens with a 36-bit response word. The word comes from a response port that has a valid flag; when no response is pending, the field is sent as zeros. The response field is followed by the active streams in ascending stream index. Each stream is sent as a 4-bit tag, then a 6-bit length field in bytes, then its sample blocks MSB first, then zero padding up to a byte boundary. Each stream sends one or two sample blocks per frame, chosen by its rate input: one block is the 48 kHz rate and two blocks is the 96 kHz rate.

Sample data and the response word are offered through valid/ready ports. The ready signals are high only in the clock cycle that detects the start of a frame. A stream that is not valid in that cycle is left out of the frame, and so is a stream that would not fit into what remains of the 500 slots. All slots after the last stream are driven as zeros.

Top module: `ifr_top`

## Requirements
- R1: A rising edge of `sync_i` seen at a clock edge starts a frame. Slot 499 appears on `sdi_o` after the following clock edge, and one slot follows per clock. A new rising edge restarts the frame at once, even in the middle of a frame.
- R2: Slots 499..464 carry the 36-bit response, bit 35 first. This is the word on `resp_data_i` at the frame-start edge when `resp_valid_i` was high then; otherwise the field is all zeros.
- R3: Admitted streams follow in ascending index. Each stream starts with its 4-bit tag `cfg_tag_i[4s+3:4s]`, MSB first.
- R4: The tag is followed by a 6-bit length field, MSB first. It equals ceil(nblk*CH_CNT*SMP_W/8), where nblk is 2 when `cfg_dbl_i[s]` is 1 and 1 otherwise.
- R5: After the length field come nblk*CH_CNT*SMP_W payload bits, taken from stream word `in_data_i[s*PAY_W +: PAY_W]` starting at its MSB. Block 1 occupies the upper CH_CNT*SMP_W bits and block 2 the lower half. Within a block, channel 0 is uppermost and each sample is sent MSB first.
- R6: Zero bits follow the payload up to the byte boundary given by the length field; the next stream starts directly after them.
- R7: A stream whose `in_valid_i[s]` is low at the frame-start edge is omitted entirely: no tag is sent, and the next admitted stream follows directly.
- R8: A stream is admitted only if 36 + the sizes of the earlier admitted streams + its own size (10 + 8*length) is at most 500. A stream that does not fit is omitted, and later streams are still considered. A frame that totals exactly 500 slots is sent complete.
- R9: Slots after the last stream are zero. `sdi_o` stays zero after slot 0 until the next frame start, and it is zero out of reset.
- R10: `resp_ready_o` and every bit of `in_ready_o` are high only in the frame-start cycle. Data is taken at that edge only, so changes to the inputs afterwards do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; outputs change on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Shared frame-sync line; a rising edge starts a frame |
| resp_valid_i | input | 1 | Response word pending |
| resp_data_i | input | 36 | Response word |
| resp_ready_o | output | 1 | Response taken at this edge if valid |
| cfg_tag_i | input | NUM_STRM*4 | Per-stream 4-bit tag |
| cfg_dbl_i | input | NUM_STRM | Per-stream rate: 1 sends two blocks per frame |
| in_valid_i | input | NUM_STRM | Per-stream sample word valid |
| in_data_i | input | NUM_STRM*PAY_W | Per-stream sample word (two blocks) |
| in_ready_o | output | NUM_STRM | Per-stream sample word taken at this edge if valid |
| sdi_o | output | 1 | Inbound serial data line |

## Verification
The bench builds the block with NUM_STRM=5, CH_CNT=3 and SMP_W=20. With these values a single-block stream ends in 4 pad bits, a two-block stream fills exactly 15 bytes with no padding, and a two-block stream takes 130 slots. Under this configuration four two-block streams overflow the frame, while three two-block streams plus one single-block stream fill all 500 slots exactly. These cases bring both the admission overflow and the exact-fit boundary within reach. The bench also sweeps all 32 stream-valid masks with varying rate patterns, tags and response presence, and aborts one frame midway with a new sync edge.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  localparam int unsigned RESP_W      = 36;
  localparam int unsigned FRAME_SLOTS = 500;
  localparam int unsigned TAG_W       = 4;
  localparam int unsigned LEN_W       = 6;
  localparam int unsigned HDR_W       = TAG_W + LEN_W;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RESP,
    PH_STRM,
    PH_FILL
  } ifr_phase_e;

  // payload bits a stream sends in one frame
  function automatic int unsigned strm_bits(int unsigned blk_w, logic dbl);
    return dbl ? 2 * blk_w : blk_w;
  endfunction

  // value of the length field: payload rounded up to whole bytes
  function automatic int unsigned strm_bytes(int unsigned blk_w, logic dbl);
    return (strm_bits(blk_w, dbl) + 7) / 8;
  endfunction

  // slots a whole stream occupies: header plus padded payload
  function automatic int unsigned strm_slots(int unsigned blk_w, logic dbl);
    return HDR_W + 8 * strm_bytes(blk_w, dbl);
  endfunction

endpackage

// File: rtl/ifr_sof_detect.sv
module ifr_sof_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic sof_o
);

  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign sof_o = sync_i & ~sync_q;

  AST_SOF_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o); // R1

endmodule

// File: rtl/ifr_admit.sv
module ifr_admit
  import ifr_pkg::*;
#(
  parameter int unsigned NUM_STRM = 5,
  parameter int unsigned BLK_W    = 60
) (
  input  logic [NUM_STRM-1:0] valid_i,
  input  logic [NUM_STRM-1:0] dbl_i,
  output logic [NUM_STRM-1:0] admit_o
);

  // greedy fit in ascending index; an oversize stream does not block later ones
  always_comb begin
    int unsigned used;
    used    = RESP_W;
    admit_o = '0;
    for (int s = 0; s < int'(NUM_STRM); s++) begin
      if (valid_i[s] && (used + strm_slots(BLK_W, dbl_i[s]) <= FRAME_SLOTS)) begin
        admit_o[s] = 1'b1;
        used       = used + strm_slots(BLK_W, dbl_i[s]);
      end
    end
  end

endmodule

// File: rtl/ifr_lane.sv
module ifr_lane
  import ifr_pkg::*;
#(
  parameter int unsigned BLK_W = 60,
  parameter int unsigned POS_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic                 dbl_i,
  input  logic [2*BLK_W-1:0]   data_i,
  input  logic [POS_W-1:0]     pos_i,
  output logic                 bit_o,
  output logic                 last_o
);

  localparam int unsigned PAY_W = 2 * BLK_W;
  localparam int unsigned TOT_W = HDR_W + 8 * ((PAY_W + 7) / 8);
  localparam int unsigned PAD_W = TOT_W - HDR_W - PAY_W;

  logic [TAG_W-1:0] tag_q;
  logic             dbl_q;
  logic [PAY_W-1:0] pay_q;
  logic [PAY_W-1:0] pay_sel;
  logic [LEN_W-1:0] len;
  logic [TOT_W-1:0] vec;
  logic [TOT_W-1:0] vec_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      dbl_q <= 1'b0;
      pay_q <= '0;
    end else if (load_i) begin
      tag_q <= tag_i;
      dbl_q <= dbl_i;
      pay_q <= data_i;
    end
  end

  // single-block rate: lower block forced to zero so it reads as padding
  assign pay_sel = dbl_q ? pay_q : {pay_q[PAY_W-1 -: BLK_W], {BLK_W{1'b0}}};
  assign len     = LEN_W'(strm_bytes(BLK_W, dbl_q));

  // whole stream image, MSB is the first bit on the line
  always_comb begin
    vec    = TOT_W'({tag_q, len, pay_sel}) << PAD_W;
    vec_sh = vec << pos_i;
    bit_o  = vec_sh[TOT_W-1];
  end

  assign last_o = (32'(pos_i) + 32'd1 == strm_slots(BLK_W, dbl_q));

endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
#(
  parameter int unsigned NUM_STRM = 5,
  parameter int unsigned POS_W    = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic [NUM_STRM-1:0] admit_i,
  input  logic                resp_valid_i,
  input  logic [RESP_W-1:0]   resp_data_i,
  input  logic [NUM_STRM-1:0] lane_bit_i,
  input  logic [NUM_STRM-1:0] lane_last_i,
  output logic [POS_W-1:0]    pos_o,
  output logic [IDX_W-1:0]    cur_o,
  output logic                sdi_o
);

  localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS);

  ifr_phase_e          ph_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [POS_W-1:0]    pos_q;
  logic [IDX_W-1:0]    cur_q;
  logic [NUM_STRM-1:0] admit_q;
  logic [RESP_W-1:0]   resp_q;
  logic                sdi_q;

  logic [IDX_W-1:0]    first_idx;
  logic                first_ok;
  logic [IDX_W-1:0]    next_idx;
  logic                next_ok;
  logic [RESP_W-1:0]   resp_sh;
  logic                bit_now;
  logic                resp_end;
  logic                frame_end;

  // lowest admitted stream, and lowest admitted stream above the current one
  always_comb begin
    first_idx = '0;
    first_ok  = 1'b0;
    next_idx  = '0;
    next_ok   = 1'b0;
    for (int i = 0; i < int'(NUM_STRM); i++) begin
      if (admit_q[i] && !first_ok) begin
        first_idx = IDX_W'(i);
        first_ok  = 1'b1;
      end
      if (admit_q[i] && !next_ok && (i > int'(cur_q))) begin
        next_idx = IDX_W'(i);
        next_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    resp_sh = resp_q << pos_q;
    unique case (ph_q)
      PH_RESP: bit_now = resp_sh[RESP_W-1];
      PH_STRM: bit_now = lane_bit_i[cur_q];
      default: bit_now = 1'b0;
    endcase
  end

  assign resp_end  = (pos_q == POS_W'(RESP_W - 1));
  assign frame_end = (slot_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      slot_q  <= '0;
      pos_q   <= '0;
      cur_q   <= '0;
      admit_q <= '0;
      resp_q  <= '0;
      sdi_q   <= 1'b0;
    end else if (sof_i) begin
      ph_q    <= PH_RESP;
      slot_q  <= SLOT_W'(FRAME_SLOTS - 1);
      pos_q   <= '0;
      cur_q   <= '0;
      admit_q <= admit_i;
      resp_q  <= resp_valid_i ? resp_data_i : '0;
      sdi_q   <= 1'b0;
    end else if (ph_q != PH_IDLE) begin
      sdi_q  <= bit_now;
      slot_q <= slot_q - 1'b1;
      if (frame_end) begin
        ph_q <= PH_IDLE;
      end else begin
        unique case (ph_q)
          PH_RESP: begin
            if (resp_end) begin
              pos_q <= '0;
              cur_q <= first_idx;
              ph_q  <= first_ok ? PH_STRM : PH_FILL;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
          PH_STRM: begin
            if (lane_last_i[cur_q]) begin
              pos_q <= '0;
              cur_q <= next_idx;
              ph_q  <= next_ok ? PH_STRM : PH_FILL;
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end else begin
      sdi_q <= 1'b0;
    end
  end

  assign pos_o = pos_q;
  assign cur_o = cur_q;
  assign sdi_o = sdi_q;

  AST_SOF_STARTS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (ph_q == PH_RESP && slot_q == SLOT_W'(FRAME_SLOTS - 1))); // R1

  AST_STRM_ADMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_STRM) |-> admit_q[cur_q]); // R7

  AST_NO_TRUNCATION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_STRM && frame_end) |-> lane_last_i[cur_q]); // R8

  AST_QUIET_AFTER_STREAMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ph_q == PH_FILL || ph_q == PH_IDLE) && !sof_i) |=> !sdi_o); // R9

endmodule

// File: rtl/ifr_top.sv
module ifr_top
  import ifr_pkg::*;
#(
  parameter int unsigned NUM_STRM = 5,
  parameter int unsigned CH_CNT   = 3,
  parameter int unsigned SMP_W    = 20,
  localparam int unsigned BLK_W   = CH_CNT * SMP_W,
  localparam int unsigned PAY_W   = 2 * BLK_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sync_i,
  input  logic                       resp_valid_i,
  input  logic [35:0]                resp_data_i,
  output logic                       resp_ready_o,
  input  logic [NUM_STRM*4-1:0]      cfg_tag_i,
  input  logic [NUM_STRM-1:0]        cfg_dbl_i,
  input  logic [NUM_STRM-1:0]        in_valid_i,
  input  logic [NUM_STRM*PAY_W-1:0]  in_data_i,
  output logic [NUM_STRM-1:0]        in_ready_o,
  output logic                       sdi_o
);

  localparam int unsigned MAX_SLOTS = HDR_W + 8 * ((PAY_W + 7) / 8);
  localparam int unsigned POS_MAX   = (MAX_SLOTS > RESP_W) ? MAX_SLOTS : RESP_W;
  localparam int unsigned POS_W     = $clog2(POS_MAX + 1);
  localparam int unsigned IDX_W     = (NUM_STRM > 1) ? $clog2(NUM_STRM) : 1;

  logic                sof;
  logic [NUM_STRM-1:0] admit;
  logic [NUM_STRM-1:0] lane_bit;
  logic [NUM_STRM-1:0] lane_last;
  logic [POS_W-1:0]    pos;
  logic [IDX_W-1:0]    cur;

  ifr_sof_detect u_sof (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .sof_o  (sof)
  );

  ifr_admit #(
    .NUM_STRM (NUM_STRM),
    .BLK_W    (BLK_W)
  ) u_admit (
    .valid_i (in_valid_i),
    .dbl_i   (cfg_dbl_i),
    .admit_o (admit)
  );

  for (genvar s = 0; s < int'(NUM_STRM); s++) begin : g_lane
    ifr_lane #(
      .BLK_W (BLK_W),
      .POS_W (POS_W)
    ) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (sof & in_valid_i[s]),
      .tag_i  (cfg_tag_i[s*TAG_W +: TAG_W]),
      .dbl_i  (cfg_dbl_i[s]),
      .data_i (in_data_i[s*PAY_W +: PAY_W]),
      .pos_i  (pos),
      .bit_o  (lane_bit[s]),
      .last_o (lane_last[s])
    );
  end

  ifr_seq #(
    .NUM_STRM (NUM_STRM),
    .POS_W    (POS_W),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sof_i        (sof),
    .admit_i      (admit),
    .resp_valid_i (resp_valid_i),
    .resp_data_i  (resp_data_i),
    .lane_bit_i   (lane_bit),
    .lane_last_i  (lane_last),
    .pos_o        (pos),
    .cur_o        (cur),
    .sdi_o        (sdi_o)
  );

  assign resp_ready_o = sof;
  assign in_ready_o   = {NUM_STRM{sof}};

  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_ready_o |=> (!resp_ready_o && in_ready_o == '0)); // R10

endmodule

// File: tb/ifr_top_tb.sv
module ifr_top_tb_top;

  localparam int NS    = 5;
  localparam int CH    = 3;
  localparam int SW    = 20;
  localparam int BLK   = CH * SW;
  localparam int PAY   = 2 * BLK;
  localparam int SLOTS = 500;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sync_i;
  logic              resp_valid;
  logic [35:0]       resp_data;
  logic              resp_ready;
  logic [NS*4-1:0]   tags;
  logic [NS-1:0]     dbl;
  logic [NS-1:0]     valid;
  logic [NS*PAY-1:0] data;
  logic [NS-1:0]     ready;
  logic              sdi;

  int checks   = 0;
  int failures = 0;
  int frame_no = 0;
  bit done     = 1'b0;

  logic exp_b [SLOTS];
  int   lab   [SLOTS];
  logic got   [SLOTS];
  bit   excl;

  always #5 clk = ~clk;

  ifr_top #(.NUM_STRM(NS), .CH_CNT(CH), .SMP_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_i),
    .resp_valid_i(resp_valid), .resp_data_i(resp_data), .resp_ready_o(resp_ready),
    .cfg_tag_i(tags), .cfg_dbl_i(dbl), .in_valid_i(valid), .in_data_i(data),
    .in_ready_o(ready), .sdi_o(sdi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string lab_req(int l);
    case (l)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R9";
    endcase
  endfunction

  // bench model of one frame, from the requirements
  task automatic build_exp(input logic [NS-1:0] v, input logic [NS-1:0] d, input logic rv);
    int idx  = 0;
    int used = 36;
    excl = 1'b0;
    for (int b = 0; b < 36; b++) begin
      exp_b[idx] = rv ? resp_data[35-b] : 1'b0; lab[idx] = 2; idx++;
    end
    for (int s = 0; s < NS; s++) begin
      if (v[s]) begin
        int nb = d[s] ? 2 * BLK : BLK;
        int by = (nb + 7) / 8;
        int sz = 10 + 8 * by;
        if (used + sz <= SLOTS) begin
          for (int b = 3; b >= 0; b--) begin exp_b[idx] = tags[s*4+b]; lab[idx] = 3; idx++; end
          for (int b = 5; b >= 0; b--) begin exp_b[idx] = by[b]; lab[idx] = 4; idx++; end
          for (int j = 0; j < nb; j++) begin
            exp_b[idx] = data[s*PAY + PAY-1-j]; lab[idx] = 5; idx++;
          end
          for (int j = nb; j < 8 * by; j++) begin exp_b[idx] = 1'b0; lab[idx] = 6; idx++; end
          used += sz;
        end else begin
          excl = 1'b1;
        end
      end
    end
    while (idx < SLOTS) begin exp_b[idx] = 1'b0; lab[idx] = 9; idx++; end
  endtask

  // called at a negedge; returns at a negedge
  task automatic run_frame(input logic [NS-1:0] v, input logic [NS-1:0] d,
                           input logic rv, input int abort_at, input bit restart);
    int last = SLOTS - 1;
    int mm_lab [10];
    int first_bad [10];
    int present [10];
    int mm_all = 0;
    frame_no++;
    for (int s = 0; s < NS; s++) begin
      tags[s*4 +: 4] = 4'((s * 5 + frame_no * 3 + 1) & 15);
      data[s*PAY +: PAY] = PAY'({$urandom, $urandom, $urandom, $urandom});
    end
    dbl        = d;
    valid      = v;
    resp_valid = rv;
    resp_data  = {$urandom, $urandom};
    sync_i     = 1'b1;
    build_exp(v, d, rv);
    #1;
    chk(ready == '1 && resp_ready, "R10", "ready at frame start",
        longint'({resp_ready, ready}), longint'({1'b1, {NS{1'b1}}}));
    @(posedge clk);
    @(negedge clk);
    chk(ready == '0 && !resp_ready, "R10", "ready after frame start",
        longint'({resp_ready, ready}), 0);
    data       = ~data;
    resp_data  = ~resp_data;
    valid      = '0;
    resp_valid = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      @(posedge clk);
      @(negedge clk);
      got[i] = sdi;
      if (i == 7) sync_i = 1'b0;
      if (abort_at >= 0 && i == abort_at) begin last = i; break; end
    end
    for (int l = 0; l < 10; l++) begin mm_lab[l] = 0; first_bad[l] = -1; present[l] = 0; end
    for (int i = 0; i <= last; i++) begin
      present[lab[i]]++;
      if (got[i] !== exp_b[i]) begin
        mm_all++;
        mm_lab[lab[i]]++;
        if (first_bad[lab[i]] < 0) first_bad[lab[i]] = i;
      end
    end
    chk(got[0] === exp_b[0], "R1", "slot 499 after frame start", longint'(got[0]), longint'(exp_b[0]));
    for (int l = 2; l < 10; l++) begin
      if (present[l] > 0) begin
        string w;
        w = $sformatf("frame %0d field mismatches (first at bit %0d)", frame_no, first_bad[l]);
        chk(mm_lab[l] == 0, lab_req(l), w, mm_lab[l], 0);
      end
    end
    if (v != '1) chk(mm_all == 0, "R7", "frame with omitted streams", mm_all, 0);
    if (excl)    chk(mm_all == 0, "R8", "frame with oversize stream", mm_all, 0);
    if (restart) chk(mm_all == 0, "R1", "frame restarted mid-frame", mm_all, 0);
    if (abort_at < 0) begin
      int nz = 0;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); @(negedge clk);
        if (sdi !== 1'b0) nz++;
      end
      chk(nz == 0, "R9", "line idle after slot 0", nz, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_i = 1'b0; resp_valid = 1'b0; resp_data = '0;
    tags = '0; dbl = '0; valid = '0; data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(sdi === 1'b0, "R9", "line after reset", longint'(sdi), 0);
    chk(ready == '0 && !resp_ready, "R10", "ready after reset", longint'({resp_ready, ready}), 0);
    repeat (2) @(negedge clk);

    run_frame(5'b11111, 5'b00000, 1'b1, -1, 1'b0); // all single rate, padding R6
    run_frame(5'b00000, 5'b00000, 1'b0, -1, 1'b0); // empty frame, zero response R2
    run_frame(5'b01010, 5'b00010, 1'b1, -1, 1'b0); // sparse R7
    run_frame(5'b11111, 5'b01111, 1'b1, -1, 1'b0); // 3 double excluded, 4 single exact fit R8
    run_frame(5'b11111, 5'b11111, 1'b0, -1, 1'b0); // two streams excluded R8
    run_frame(5'b10111, 5'b10111, 1'b1, -1, 1'b0); // stream 3 invalid, 4 excluded
    run_frame(5'b11111, 5'b00000, 1'b1, 120, 1'b0); // aborted by new sync
    run_frame(5'b01101, 5'b00101, 1'b1, -1, 1'b1); // restart R1
    for (int m = 0; m < 32; m++) begin
      run_frame(5'(m), 5'((m * 11 + 3) & 31), m[0], -1, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule